// File: doc/BRIEF.md
# Multiplexed-Bus Byte EEPROM with Unlock Sequence

This block is the slave side of a byte-wide nonvolatile memory that sits on a multiplexed microcontroller bus. The same eight pins carry the low address byte and the data byte. The master presents the low address first and marks it with an address strobe while the chip is enabled. It then either raises the read strobe, and the block drives the stored byte back on the shared pins, or it raises the write strobe with the data byte on those pins. The upper address bits arrive on their own pins and join the latched low byte to form the full address.

The array is protected twice. A protect input must be low, and a three-write unlock sequence must arrive before a fourth write can change a byte. The sequence is 0x55 to the first key address, 0xAA to the second key address, then 0xA0 to the first key address again. Any other write, any read, or any write made while protect is high sends the sequence back to its start. The default array holds 2 K bytes, with three upper address pins and key addresses 0x555 and 0x2AA. Setting five upper pins and key addresses 0x1555 and 0x0AAA gives the 8 K-byte arrangement. The shared pins are modelled as a separate input, output and output-enable, so that a pad ring outside the block can build the bidirectional pins.

Top module: `mbe_eeprom`

## Requirements
- R1: While reset is held and after it is released, `ad_oe` is 0, every byte reads 0xFF, and the unlock sequence is at its start.
- R2: At a clock edge where `chip_en` and `addr_stb` are both 1, the low address byte is taken from `ad_in`. It holds its value at every other edge. The full address is `{addr_hi, low byte}`.
- R3: While `chip_en` and `rd_stb` are both 1, `ad_oe` is 1 and `ad_out` shows the byte at the current full address in that same cycle. Otherwise `ad_oe` is 0 and `ad_out` is 0x00.
- R4: A write is taken once, at the first edge of a run of cycles with `wr_stb` high while `chip_en` is 1. Its data is `ad_in` and its address is the current full address. Holding `wr_stb` high for more cycles adds no further writes.
- R5: The writes 0x55 at KEY_A1, then 0xAA at KEY_A2, then 0xA0 at KEY_A1 (defaults 0x555, 0x2AA, 0x555) arm the array. The next write stores its data at its own address, and the new byte reads back from the following cycle on.
- R6: A write that is not preceded by the complete unlock sequence leaves the array unchanged.
- R7: A write whose address or data does not match the expected unlock step returns the sequence to its start. All three unlock writes are then needed again.
- R8: A read cycle in the middle of the unlock sequence returns the sequence to its start.
- R9: While `wr_protect` is 1, a write changes no byte and returns the sequence to its start. This holds even when the sequence is armed.
- R10: After a write has been stored, the sequence is back at its start, so a further plain write changes nothing.
- R11: With `chip_en` at 0, the address, read and write strobes have no effect: no capture, no drive and no sequence step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip enable, active high |
| addr_stb | input | 1 | Low-address capture strobe |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_protect | input | 1 | Write protect, 1 blocks every change |
| addr_hi | input | HI_W (3) | Upper address bits |
| ad_in | input | BUS_W (8) | Shared pins, inbound: low address or write data |
| ad_out | output | BUS_W (8) | Shared pins, outbound read data |
| ad_oe | output | 1 | Drive enable for the shared pins |

## Verification
Read data and `ad_oe` are combinational on the strobes. They are due in the same cycle as the read strobe, using the low address captured at the edge that closed the previous address cycle. A stored byte, a captured address and each unlock step take effect at the edge that ends the write or address cycle, and become visible one cycle later. The bench drives inputs on the falling edge. One nanosecond later it compares `ad_oe` and `ad_out` against a behavioural model that advances on the rising edge, so every comparison falls after that cycle's inputs have settled and before the next edge moves any register. Directed reads check the expected bytes for each unlock corner case against constants.

// File: rtl/mbe_pkg.sv
package mbe_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_KEY1  = 2'd1,
        SEQ_KEY2  = 2'd2,
        SEQ_ARMED = 2'd3
    } seq_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [7:0] KEY_THIRD  = 8'hA0;
    localparam logic [7:0] ERASED_VAL = 8'hFF;

endpackage

// File: rtl/mbe_unlock_seq.sv
module mbe_unlock_seq
    import mbe_pkg::*;
#(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8,
    parameter logic [AW-1:0] KEY_A1 = 'h555,
    parameter logic [AW-1:0] KEY_A2 = 'h2AA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_evt,
    input  logic          rd_evt,
    input  logic          protect,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          commit,
    output seq_e          state
);

    typedef struct packed {
        seq_e st;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic hit1, hit2, hit3;

    always_comb begin
        hit1   = (addr == KEY_A1) && (data == DW'(KEY_FIRST));
        hit2   = (addr == KEY_A2) && (data == DW'(KEY_SECOND));
        hit3   = (addr == KEY_A1) && (data == DW'(KEY_THIRD));
        s_d    = s_q;
        commit = 1'b0;
        if (rd_evt) begin
            s_d.st = SEQ_IDLE;
        end else if (wr_evt) begin
            if (protect) begin
                s_d.st = SEQ_IDLE;
            end else begin
                unique case (s_q.st)
                    SEQ_IDLE:  s_d.st = hit1 ? SEQ_KEY1  : SEQ_IDLE;
                    SEQ_KEY1:  s_d.st = hit2 ? SEQ_KEY2  : SEQ_IDLE;
                    SEQ_KEY2:  s_d.st = hit3 ? SEQ_ARMED : SEQ_IDLE;
                    SEQ_ARMED: begin
                        commit = 1'b1;
                        s_d.st = SEQ_IDLE;
                    end
                    default:   s_d.st = SEQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st <= SEQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign state = s_q.st;

endmodule

// File: rtl/mbe_cell_array.sv
module mbe_cell_array #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] ERASED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= ERASED;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/mbe_eeprom.sv
module mbe_eeprom
    import mbe_pkg::*;
#(
    parameter int unsigned HI_W  = 3,
    parameter int unsigned BUS_W = 8,
    parameter logic [HI_W+BUS_W-1:0] KEY_A1 = 'h555,
    parameter logic [HI_W+BUS_W-1:0] KEY_A2 = 'h2AA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             addr_stb,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             wr_protect,
    input  logic [HI_W-1:0]  addr_hi,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe
);

    localparam int unsigned AW = HI_W + BUS_W;

    typedef struct packed {
        logic [BUS_W-1:0] addr_lo;
        logic             wr_prev;
    } bus_regs_t;

    bus_regs_t r_d, r_q;

    logic             wr_evt;
    logic             rd_evt;
    logic             commit;
    seq_e             seq_state;
    logic [AW-1:0]    full_addr;
    logic [BUS_W-1:0] rdata;

    always_comb begin
        r_d = r_q;
        if (chip_en && addr_stb) begin
            r_d.addr_lo = ad_in;
        end
        r_d.wr_prev = wr_stb;
        wr_evt      = chip_en && wr_stb && !r_q.wr_prev;
        rd_evt      = chip_en && rd_stb;
        full_addr   = {addr_hi, r_q.addr_lo};
        ad_oe       = rd_evt;
        ad_out      = rd_evt ? rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    mbe_unlock_seq #(
        .AW     (AW),
        .DW     (BUS_W),
        .KEY_A1 (KEY_A1),
        .KEY_A2 (KEY_A2)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_evt  (wr_evt),
        .rd_evt  (rd_evt),
        .protect (wr_protect),
        .addr    (full_addr),
        .data    (ad_in),
        .commit  (commit),
        .state   (seq_state)
    );

    mbe_cell_array #(
        .AW     (AW),
        .DW     (BUS_W),
        .ERASED (BUS_W'(ERASED_VAL))
    ) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (full_addr),
        .wdata (ad_in),
        .raddr (full_addr),
        .rdata (rdata)
    );

endmodule

// File: rtl/mbe_eeprom_chk.sv
module mbe_eeprom_chk #(
    parameter int unsigned AW    = 11,
    parameter int unsigned BUS_W = 8,
    parameter logic [AW-1:0] KEY_A1 = 'h555
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_en,
    input logic             addr_stb,
    input logic             rd_stb,
    input logic             wr_protect,
    input logic [BUS_W-1:0] ad_in,
    input logic             ad_oe,
    input logic [BUS_W-1:0] addr_lo,
    input logic [1:0]       seq_state,
    input logic             commit,
    input logic             wr_evt,
    input logic [AW-1:0]    full_addr
);

    p_lo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_en && addr_stb) |=> $stable(addr_lo));

    p_lo_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && addr_stb) |=> addr_lo == $past(ad_in));

    p_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |-> !ad_oe);

    p_first_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd1 && $past(seq_state) == 2'd0)
        |-> $past(wr_evt && full_addr == KEY_A1 && ad_in == BUS_W'(8'h55)));

    p_read_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && rd_stb) |=> seq_state == 2'd0);

    p_protect_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && wr_protect) |=> seq_state == 2'd0);

    p_commit_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> seq_state == 2'd0);

    p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> !ad_oe && !wr_evt);

endmodule

bind mbe_eeprom mbe_eeprom_chk #(
    .AW     (AW),
    .BUS_W  (BUS_W),
    .KEY_A1 (KEY_A1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .addr_stb   (addr_stb),
    .rd_stb     (rd_stb),
    .wr_protect (wr_protect),
    .ad_in      (ad_in),
    .ad_oe      (ad_oe),
    .addr_lo    (r_q.addr_lo),
    .seq_state  (seq_state),
    .commit     (commit),
    .wr_evt     (wr_evt),
    .full_addr  (full_addr)
);

// File: tb/sim_mbe_eeprom.sv
`timescale 1ns/1ps
module sim_mbe_eeprom;

    localparam logic [10:0] A1 = 11'h555;
    localparam logic [10:0] A2 = 11'h2AA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0, addr_stb = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic       wr_protect = 1'b0;
    logic [2:0] addr_hi = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [7:0] ref_mem [0:2047];
    int         ref_step;
    logic [7:0] ref_lo;
    bit         ref_wprev;

    always #2 clk = ~clk;

    mbe_eeprom u0 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr_stb(addr_stb),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_protect(wr_protect),
        .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) ref_mem[i] = 8'hFF;
            ref_step = 0; ref_lo = 8'h00; ref_wprev = 1'b0;
        end else begin
            bit   w, r;
            int   a;
            w = chip_en && wr_stb && !ref_wprev;
            r = chip_en && rd_stb;
            a = {addr_hi, ref_lo};
            if (r) ref_step = 0;
            else if (w) begin
                if (wr_protect) ref_step = 0;
                else if (ref_step == 3) begin ref_mem[a] = ad_in; ref_step = 0; end
                else if (ref_step == 0 && a == A1 && ad_in == 8'h55) ref_step = 1;
                else if (ref_step == 1 && a == A2 && ad_in == 8'hAA) ref_step = 2;
                else if (ref_step == 2 && a == A1 && ad_in == 8'hA0) ref_step = 3;
                else ref_step = 0;
            end
            if (chip_en && addr_stb) ref_lo = ad_in;
            ref_wprev = wr_stb;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic       eoe;
            logic [7:0] eout;
            eoe  = chip_en && rd_stb;
            eout = eoe ? ref_mem[{addr_hi, ref_lo}] : 8'h00;
            chk({cur_req, " oe"}, {7'd0, ad_oe}, {7'd0, eoe});
            chk({cur_req, " data"}, ad_out, eout);
        end
    end

    task automatic drive(input bit ce, stb, rd, wr, input logic [2:0] hi, input logic [7:0] din);
        @(negedge clk);
        chip_en = ce; addr_stb = stb; rd_stb = rd; wr_stb = wr;
        addr_hi = hi; ad_in = din;
    endtask

    task automatic write_ce(input bit ce, input logic [10:0] a, input logic [7:0] d);
        drive(ce, 1, 0, 0, a[10:8], a[7:0]);
        drive(ce, 0, 0, 1, a[10:8], d);
        drive(ce, 0, 0, 0, a[10:8], d);
    endtask

    task automatic write_b(input logic [10:0] a, input logic [7:0] d);
        write_ce(1'b1, a, d);
    endtask

    task automatic read_b(input logic [10:0] a, input logic [7:0] exp, input string req);
        drive(1, 1, 0, 0, a[10:8], a[7:0]);
        drive(1, 0, 1, 0, a[10:8], 8'h00);
        #1;
        chk(req, ad_out, exp);
        chk(req, {7'd0, ad_oe}, 8'd1);
        drive(1, 0, 0, 0, a[10:8], 8'h00);
    endtask

    task automatic unlock();
        write_b(A1, 8'h55);
        write_b(A2, 8'hAA);
        write_b(A1, 8'hA0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 oe in reset", {7'd0, ad_oe}, 8'd0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 oe after reset", {7'd0, ad_oe}, 8'd0);
        read_b(11'h000, 8'hFF, "R1 erased low");
        read_b(11'h7FF, 8'hFF, "R1 erased high");

        cur_req = "R6";
        write_b(11'h010, 8'h12);
        read_b(11'h010, 8'hFF, "R6 plain write ignored");

        cur_req = "R5";
        unlock();
        write_b(11'h010, 8'h3C);
        read_b(11'h010, 8'h3C, "R5 stored byte");
        unlock();
        write_b(11'h7FF, 8'h81);
        read_b(11'h7FF, 8'h81, "R5 top address");

        cur_req = "R2";
        read_b(11'h0FF, 8'hFF, "R2 upper pins select");
        drive(1, 1, 0, 0, 3'h7, 8'hFF);
        drive(1, 0, 0, 0, 3'h7, 8'h00);
        drive(1, 0, 1, 0, 3'h7, 8'h33);
        #1;
        chk("R2 low byte held", ad_out, 8'h81);
        drive(1, 0, 0, 0, 3'h0, 8'h00);
        #1;
        chk("R3 released after read", {7'd0, ad_oe}, 8'd0);

        cur_req = "R10";
        write_b(11'h010, 8'h99);
        read_b(11'h010, 8'h3C, "R10 no write after commit");

        cur_req = "R7";
        write_b(A1, 8'h55); write_b(A2, 8'h00); write_b(A1, 8'hA0);
        write_b(11'h020, 8'h44);
        read_b(11'h020, 8'hFF, "R7 wrong data");
        write_b(A1, 8'h55); write_b(A1, 8'hAA); write_b(A1, 8'hA0);
        write_b(11'h020, 8'h45);
        read_b(11'h020, 8'hFF, "R7 wrong address");

        cur_req = "R8";
        write_b(A1, 8'h55); write_b(A2, 8'hAA);
        read_b(11'h000, 8'hFF, "R8 mid read");
        write_b(A1, 8'hA0);
        write_b(11'h021, 8'h46);
        read_b(11'h021, 8'hFF, "R8 sequence cancelled");

        cur_req = "R9";
        wr_protect = 1'b1;
        unlock();
        write_b(11'h022, 8'h47);
        read_b(11'h022, 8'hFF, "R9 protected sequence");
        wr_protect = 1'b0;
        unlock();
        wr_protect = 1'b1;
        write_b(11'h022, 8'h48);
        wr_protect = 1'b0;
        write_b(11'h022, 8'h49);
        read_b(11'h022, 8'hFF, "R9 armed then protected");

        cur_req = "R4";
        drive(1, 1, 0, 0, A1[10:8], A1[7:0]);
        drive(1, 0, 0, 1, A1[10:8], 8'h55);
        drive(1, 0, 0, 1, A1[10:8], 8'h55);
        drive(1, 0, 0, 1, A1[10:8], 8'h55);
        drive(1, 0, 0, 0, A1[10:8], 8'h55);
        write_b(A2, 8'hAA); write_b(A1, 8'hA0);
        write_b(11'h030, 8'h5A);
        read_b(11'h030, 8'h5A, "R4 held strobe counted once");

        cur_req = "R11";
        unlock();
        write_b(11'h040, 8'h11);
        drive(1, 1, 0, 0, 3'h0, 8'h40);
        drive(0, 1, 0, 0, 3'h0, 8'h50);
        drive(1, 0, 1, 0, 3'h0, 8'h00);
        #1;
        chk("R11 capture ignored", ad_out, 8'h11);
        drive(0, 0, 1, 0, 3'h0, 8'h00);
        #1;
        chk("R11 no drive", {7'd0, ad_oe}, 8'd0);
        write_ce(1'b0, A1, 8'h55); write_ce(1'b0, A2, 8'hAA); write_ce(1'b0, A1, 8'hA0);
        write_b(11'h040, 8'h22);
        read_b(11'h040, 8'h11, "R11 writes ignored");

        drive(0, 0, 0, 0, 3'h0, 8'h00);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule